// File: doc/BRIEF.md
# Pipelined Eight-Lane Bitonic Sorter

This block takes eight unsigned 8-bit values that arrive together and returns them in ascending order. Inside, a bitonic network does the work. The first four lanes are sorted upward and the last four downward. Together the two halves form one rising run followed by one falling run. A three-layer merge then flattens that shape into a single ascending sequence. Every comparator in the merge works upward: it pairs lanes four apart, then two apart within each half, then neighbours.

There are six comparator layers in total. With `PIPELINED=1` they are grouped into five register stages: the first two layers share a stage and every later layer has a stage of its own. A whole vector can enter on every clock, and its sorted form appears five clocks later. A valid flag travels alongside the data. With `PIPELINED=0` the six layers are chained with no registers, so the sorted vector and its flag appear in the same cycle as the input. The block has no flow control: whatever is presented with the valid flag high is accepted.

Top module: `bitonic_sort8`

## Requirements
- R1: Lane i of a vector occupies bits [8*i+7 : 8*i] of `in_data`. Lane i of the result occupies the same bits of `out_data`. Lane 0 holds the smallest value.
- R2: Whenever `out_valid` is high, every lane of `out_data` is less than or equal, as an unsigned number, to the lane above it.
- R3: A result holds exactly the values of its input vector, with duplicates kept and the extremes 0 and 255 preserved.
- R4: With `PIPELINED=1`, `out_valid` equals `in_valid` as sampled five rising edges earlier. A result flagged valid is the sorted form of the vector captured at that edge.
- R5: A new vector is accepted on every clock with no stall. Vectors presented on consecutive clocks produce their results on consecutive clocks, in the same order.
- R6: `rst_n` is synchronous and active low, and clears the valid flag in every stage. `out_valid` stays low while reset is held and for the first five rising edges after it is released, whatever `in_valid` does. Vectors flagged valid during reset produce no result.
- R7: With `PIPELINED=0`, `out_data` is the sorted form of the current `in_data` in the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Synchronous active-low reset that clears the valid flags |
| in_valid | input | 1 | High when `in_data` carries a vector to sort |
| in_data | input | 64 | Eight unsorted lanes, 8 bits each, lane i at bits 8*i and up |
| out_valid | output | 1 | High when `out_data` carries a sorted result |
| out_data | output | 64 | Eight lanes in ascending order, lane 0 the smallest |

## Verification
Two things can happen in the same cycle: a new vector is captured while an older one leaves the last stage, and reset can strike while up to five vectors are still inside the pipe. The bench provokes the first with long runs of back-to-back valid vectors. It provokes the second by asserting reset in the middle of such a run while `in_valid` stays high. A reference model of five slots predicts each result by sorting the vector in software and empties all of its slots on reset. The bench compares the flag and the data against the model on every falling edge. A second, combinational instance is checked in the same cycle against the same software sort.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    // Number of lanes in one vector and the structure that follows from it.
    localparam int N_LANE     = 8;
    localparam int N_LAYER    = 6;
    localparam int N_STAGE    = 5;

    // Span of the comparison block for a given layer (2, 4 or 8).
    function automatic int layer_span(input int layer);
        int cnt;
        cnt = 0;
        for (int k = 2; k <= N_LANE; k = k * 2) begin
            for (int j = k / 2; j > 0; j = j / 2) begin
                if (cnt == layer) return k;
                cnt++;
            end
        end
        return N_LANE;
    endfunction

    // Distance between paired lanes for a given layer.
    function automatic int layer_dist(input int layer);
        int cnt;
        cnt = 0;
        for (int k = 2; k <= N_LANE; k = k * 2) begin
            for (int j = k / 2; j > 0; j = j / 2) begin
                if (cnt == layer) return j;
                cnt++;
            end
        end
        return 1;
    endfunction

    // Stage 0 carries layers 0 and 1; stage s>0 carries layer s+1.
    function automatic int stage_first(input int stg);
        return (stg == 0) ? 0 : stg + 1;
    endfunction

    function automatic int stage_count(input int stg);
        return (stg == 0) ? 2 : 1;
    endfunction

endpackage

// File: rtl/bsort_cmp.sv
module bsort_cmp #(
    parameter int W   = 8,
    parameter bit ASC = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p,
    output logic [W-1:0] q
);

    logic swap;

    always_comb begin
        swap = ASC ? (a > b) : (a < b);
        p    = swap ? b : a;
        q    = swap ? a : b;
    end

    always_comb begin
        if (!$isunknown({a, b})) begin
            AST_CMP_ORDER: assert (ASC ? (p <= q) : (p >= q)); // R2
            AST_CMP_KEEP: assert (({1'b0, p} + {1'b0, q}) == ({1'b0, a} + {1'b0, b})); // R3
        end
    end

endmodule

// File: rtl/bsort_layer.sv
module bsort_layer #(
    parameter int W    = 8,
    parameter int N    = 8,
    parameter int SPAN = 2,
    parameter int DIST = 1
) (
    input  logic [N*W-1:0] din,
    output logic [N*W-1:0] dout
);

    // Each lane whose DIST bit is clear owns a comparator with lane+DIST.
    // Direction is upward when the SPAN bit of the lane index is clear.
    for (genvar i = 0; i < N; i++) begin : g_lane
        if ((i & DIST) == 0) begin : g_cmp
            bsort_cmp #(
                .W   (W),
                .ASC ((i & SPAN) == 0)
            ) u_cmp (
                .a (din[i*W +: W]),
                .b (din[(i+DIST)*W +: W]),
                .p (dout[i*W +: W]),
                .q (dout[(i+DIST)*W +: W])
            );
        end
    end

endmodule

// File: rtl/bsort_stage.sv
module bsort_stage #(
    parameter int W     = 8,
    parameter int N     = 8,
    parameter int FIRST = 0,
    parameter int COUNT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vin,
    input  logic [N*W-1:0] din,
    output logic         vout,
    output logic [N*W-1:0] dout
);

    logic [N*W-1:0] chain [0:COUNT];

    assign chain[0] = din;

    for (genvar c = 0; c < COUNT; c++) begin : g_layer
        bsort_layer #(
            .W    (W),
            .N    (N),
            .SPAN (bsort_pkg::layer_span(FIRST + c)),
            .DIST (bsort_pkg::layer_dist(FIRST + c))
        ) u_layer (
            .din  (chain[c]),
            .dout (chain[c+1])
        );
    end

    // Only the flag is reset; the data register is qualified by it.
    always_ff @(posedge clk) begin
        if (!rst_n) vout <= 1'b0;
        else        vout <= vin;
    end

    always_ff @(posedge clk) begin
        dout <= chain[COUNT];
    end

endmodule

// File: rtl/bitonic_sort8.sv
module bitonic_sort8 #(
    parameter int W         = 8,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [bsort_pkg::N_LANE*W-1:0]   in_data,
    output logic                             out_valid,
    output logic [bsort_pkg::N_LANE*W-1:0]   out_data
);

    localparam int N    = bsort_pkg::N_LANE;
    localparam int VW   = N * W;
    localparam int NSTG = bsort_pkg::N_STAGE;
    localparam int NLAY = bsort_pkg::N_LAYER;

    if (PIPELINED) begin : g_pipe
        logic          sv [0:NSTG];
        logic [VW-1:0] sd [0:NSTG];

        assign sv[0] = in_valid;
        assign sd[0] = in_data;

        for (genvar s = 0; s < NSTG; s++) begin : g_stage
            bsort_stage #(
                .W     (W),
                .N     (N),
                .FIRST (bsort_pkg::stage_first(s)),
                .COUNT (bsort_pkg::stage_count(s))
            ) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .vin   (sv[s]),
                .din   (sd[s]),
                .vout  (sv[s+1]),
                .dout  (sd[s+1])
            );
        end

        assign out_valid = sv[NSTG];
        assign out_data  = sd[NSTG];

        // Edges seen since reset release, saturating at the latency.
        logic [2:0] since_rst;
        always_ff @(posedge clk) begin
            if (!rst_n)                 since_rst <= 3'd0;
            else if (since_rst != NSTG) since_rst <= since_rst + 3'd1;
        end

        AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == NSTG) |-> (out_valid == $past(in_valid, 5))); // R4

        AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst < NSTG) |-> !out_valid); // R6

        for (genvar i = 0; i < N - 1; i++) begin : g_order
            AST_OUT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_data[i*W +: W] <= out_data[(i+1)*W +: W])); // R2
        end
    end else begin : g_comb
        logic [VW-1:0] ld [0:NLAY];

        assign ld[0] = in_data;

        for (genvar l = 0; l < NLAY; l++) begin : g_layer
            bsort_layer #(
                .W    (W),
                .N    (N),
                .SPAN (bsort_pkg::layer_span(l)),
                .DIST (bsort_pkg::layer_dist(l))
            ) u_layer (
                .din  (ld[l]),
                .dout (ld[l+1])
            );
        end

        assign out_valid = in_valid;
        assign out_data  = ld[NLAY];

        always_comb begin
            if (!$isunknown(out_data)) begin
                for (int i = 0; i < N - 1; i++) begin
                    AST_COMB_ORDER: assert (out_data[i*W +: W] <= out_data[(i+1)*W +: W]); // R7
                end
            end
        end
    end

endmodule

// File: tb/tb_bitonic_sort8.sv
module tb_bitonic_sort8;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_data;
    logic        out_valid;
    logic [63:0] out_data;
    logic        c_valid;
    logic [63:0] c_data;

    int checks = 0;
    int errors = 0;
    int since_rst = 0;

    // Reference pipe: slot 4 is what the output should show now.
    logic        pv [0:4];
    logic [63:0] pd [0:4];

    bitonic_sort8 #(.W(8), .PIPELINED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    bitonic_sort8 #(.W(8), .PIPELINED(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(c_valid), .out_data(c_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [63:0] sort_ref(input logic [63:0] v);
        logic [7:0] a [0:7];
        logic [7:0] t;
        logic [63:0] r;
        for (int i = 0; i < 8; i++) a[i] = v[i*8 +: 8];
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 7 - i; j++) begin
                if (a[j] > a[j+1]) begin
                    t = a[j]; a[j] = a[j+1]; a[j+1] = t;
                end
            end
        end
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = a[i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: check outputs at the falling edge, then drive the next input.
    task automatic step(input logic v, input logic [63:0] d, input logic rst);
        @(negedge clk);
        if (since_rst < 5)
            chk(out_valid == pv[4], "R6 flag after reset", {63'd0, out_valid}, {63'd0, pv[4]});
        else
            chk(out_valid == pv[4], "R4 flag latency", {63'd0, out_valid}, {63'd0, pv[4]});
        if (pv[4] && out_valid)
            chk(out_data == pd[4], "R2 R3 R5 sorted result", out_data, pd[4]);
        in_valid = v;
        in_data  = d;
        rst_n    = !rst;
        for (int s = 4; s > 0; s--) begin
            pv[s] = pv[s-1];
            pd[s] = pd[s-1];
        end
        pv[0] = v;
        pd[0] = sort_ref(d);
        if (rst) begin
            for (int s = 0; s < 5; s++) pv[s] = 1'b0;
            since_rst = 0;
        end else begin
            since_rst++;
        end
        #1;
        chk(c_valid == v, "R7 comb flag", {63'd0, c_valid}, {63'd0, v});
        chk(c_data == sort_ref(d), "R7 R1 comb data", c_data, sort_ref(d));
    endtask

    function automatic logic [63:0] rand_vec(input int mode);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            case (mode)
                0:       r[i*8 +: 8] = 8'($urandom);
                1:       r[i*8 +: 8] = 8'($urandom % 4);
                default: r[i*8 +: 8] = ($urandom % 2) ? 8'hFF : 8'h00;
            endcase
        end
        return r;
    endfunction

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        for (int s = 0; s < 5; s++) begin
            pv[s] = 1'b0;
            pd[s] = '0;
        end
        void'($urandom(32'h5EED_0A17));

        // Reset held, in_valid high: nothing may come out (R6).
        step(1'b1, 64'h0102030405060708, 1'b1);
        step(1'b1, 64'h1111111111111111, 1'b1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 reset state", {63'd0, out_valid}, 64'd0);

        // Directed corner vectors, back to back (R1, R3, R5).
        step(1'b1, 64'h0001020304050607, 1'b0); // descending lanes
        step(1'b1, 64'h0706050403020100, 1'b0); // already ascending
        step(1'b1, 64'h0000000000000000, 1'b0); // all zero
        step(1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b0); // all max
        step(1'b1, 64'hFF00FF00FF00FF00, 1'b0); // extremes mixed
        step(1'b1, 64'h5A5A5A5A5A5A5A00, 1'b0); // one distinct low
        step(1'b1, 64'h00000000000000FF, 1'b0); // one max in lane 0
        step(1'b0, 64'hDEADBEEFCAFEF00D, 1'b0); // not valid: R4
        step(1'b1, 64'h80017F0281FE7E03, 1'b0);

        // Long fully valid random run (R5).
        for (int n = 0; n < 200; n++) step(1'b1, rand_vec(n % 3), 1'b0);

        // Reset strikes with vectors in flight (R6).
        step(1'b1, rand_vec(0), 1'b1);
        for (int n = 0; n < 10; n++) step(1'b1, rand_vec(0), 1'b0);

        // Random flags and values (R4).
        for (int n = 0; n < 600; n++) step(($urandom % 4) != 0, rand_vec(n % 3), 1'b0);

        // Drain.
        for (int n = 0; n < 6; n++) step(1'b0, 64'd0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule